// File: doc/BRIEF.md
# Buck Converter Soft-Start and Protection Sequencer

This block is the digital sequencer of a single-phase step-down regulator. It watches the two supply-good flags, the enable flag and three output comparators, and decides what the gate drivers do, which reference code the reference DAC gets, and when the power-good output is released. All time inside the block is counted in ticks of the switching clock, so the sequence scales with the programmed switching frequency.

After both supplies are good and enable is asserted, the sequencer waits a fixed number of ticks. It then raises the reference code by one per tick until the code reaches full scale. Power-good follows three ticks later. An undervoltage reported late in the ramp restarts the whole start-up. An undervoltage in regulation latches both gates off. An overvoltage in any state pulls the output down through the bottom gate and is latched. Dropping enable starts a discharge that ends once the output is below half the reference.

Top module: `softstart_prot_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `gate_o` is 00, `pgood_o` is 0 and `ref_code_o` is 0. Start-up begins only while `vcc_ok_i`, `vccp_ok_i` and `en_i` are all high.
- R2: A start-up first holds the gates off for DELAY_TICKS ticks. The code then starts at 0 and rises by one on each tick. It reaches full scale (all ones, 1023 by default) in RAMP_CYCLES ticks and holds full scale after that.
- R3: `pgood_o` goes high three ticks after the ramp completes. It stays high only while `uvp_i` and `ovp_i` are both low.
- R4: When `ovp_i` is high in any state with both supplies good, the next cycle has `gate_o` = 10 and `pgood_o` = 0. This latches until `ovp_i` is low and `en_i` is low together, or a supply is lost.
- R5: During the ramp, `uvp_i` is ignored while the code is below 80% of the ramp length (819 by default).
- R6: When `uvp_i` is high from the 80% point until power-good is released, the soft-start restarts. The code returns to 0 and the gates turn off, and the full delay and ramp repeat.
- R7: When `uvp_i` is high in regulation, both gates latch off (`gate_o` = 00, `pgood_o` = 0). Only `en_i` low or the loss of a supply clears this latch.
- R8: Dropping `en_i` during start-up or regulation enters discharge (`gate_o` = 10, `pgood_o` = 0, code 0). Discharge lasts until `dis_low_i` is high, and the block then goes idle.
- R9: Losing `vcc_ok_i` or `vccp_ok_i` sends the block to idle on the next cycle from any state.
- R10: The gate command encoding is 00 for both gates off, 01 for normal switching (ramp, power-good wait, regulation) and 10 for top gate off with bottom gate on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_ok_i | input | 1 | Controller supply above its lockout threshold |
| vccp_ok_i | input | 1 | Driver supply above its lockout threshold |
| en_i | input | 1 | Enable request |
| tick_i | input | 1 | One-cycle pulse per switching period |
| ovp_i | input | 1 | Output above 125% of reference |
| uvp_i | input | 1 | Output below 75% of reference |
| dis_low_i | input | 1 | Output below 50% of reference |
| ref_code_o | output | $clog2(RAMP_CYCLES) | Reference DAC code |
| pgood_o | output | 1 | Power good |
| gate_o | output | 2 | Gate command, encoded as in R10 |

## Verification
The assertions assume that every input is synchronous to `clk_i` and that `tick_i` is a single-cycle pulse. They also assume that more than one tick separates events, so a counter limit is never skipped. The stimulus changes inputs one clock after a rising edge and produces the tick as a pulse on every second cycle. Fault and enable pulses each last a whole cycle, and they land at chosen points in the sequence: early and late in the ramp, during regulation, and during the latched and discharge states.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DELAY, ST_RAMP, ST_PGWAIT, ST_RUN, ST_OVLATCH, ST_UVLATCH, ST_DISCH
  } seq_state_e;

  typedef enum logic [1:0] {
    GATE_OFF    = 2'b00,
    GATE_SWITCH = 2'b01,
    GATE_LOW_ON = 2'b10
  } gate_cmd_e;
endpackage

// File: rtl/seq_step_cnt.sv
module seq_step_cnt #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/seq_ref_map.sv
module seq_ref_map
  import seq_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter int CNT_W   = 11,
  parameter int ARM_PCT = 80
) (
  input  seq_state_e        state_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CODE_W-1:0] code_o,
  output logic              uv_armed_o
);
  localparam int RAMP_LEN = 1 << CODE_W;
  localparam logic [CNT_W-1:0] ARM_CNT = CNT_W'((RAMP_LEN * ARM_PCT) / 100);

  always_comb begin
    code_o     = '0;
    uv_armed_o = 1'b0;
    unique case (state_i)
      ST_RAMP: begin
        code_o     = cnt_i[CODE_W-1:0];
        uv_armed_o = (cnt_i >= ARM_CNT);
      end
      ST_PGWAIT: begin
        code_o     = '1;
        uv_armed_o = 1'b1;
      end
      ST_RUN:  code_o = '1;
      default: ;
    endcase
  end
endmodule

// File: rtl/softstart_prot_seq.sv
module softstart_prot_seq
  import seq_pkg::*;
#(
  parameter int RAMP_CYCLES = 1024,
  parameter int DELAY_TICKS = 16,
  parameter int PG_TICKS    = 3,
  parameter int ARM_PCT     = 80,
  localparam int CODE_W     = $clog2(RAMP_CYCLES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vcc_ok_i,
  input  logic              vccp_ok_i,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              ovp_i,
  input  logic              uvp_i,
  input  logic              dis_low_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              pgood_o,
  output logic [1:0]        gate_o
);
  localparam int MAX_CNT = (RAMP_CYCLES > DELAY_TICKS) ? RAMP_CYCLES : DELAY_TICKS;
  localparam int CNT_W   = $clog2(MAX_CNT) + 1;
  localparam logic [CNT_W-1:0] DLY_LAST  = CNT_W'(DELAY_TICKS - 1);
  localparam logic [CNT_W-1:0] RAMP_LAST = CNT_W'(RAMP_CYCLES - 1);
  localparam logic [CNT_W-1:0] PG_LAST   = CNT_W'(PG_TICKS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_clr, cnt_inc, supply_ok, uv_armed;

  assign supply_ok = vcc_ok_i & vccp_ok_i;

  always_comb begin
    state_d = state_q;
    if (!supply_ok)                           state_d = ST_IDLE;
    else if (ovp_i)                           state_d = ST_OVLATCH;
    else begin
      unique case (state_q)
        ST_IDLE:    if (en_i) state_d = ST_DELAY;
        ST_DELAY:   if (!en_i) state_d = ST_DISCH;
                    else if (tick_i && cnt_q == DLY_LAST) state_d = ST_RAMP;
        ST_RAMP:    if (!en_i) state_d = ST_DISCH;
                    else if (uvp_i && uv_armed) state_d = ST_DELAY;
                    else if (tick_i && cnt_q == RAMP_LAST) state_d = ST_PGWAIT;
        ST_PGWAIT:  if (!en_i) state_d = ST_DISCH;
                    else if (uvp_i && uv_armed) state_d = ST_DELAY;
                    else if (tick_i && cnt_q == PG_LAST) state_d = ST_RUN;
        ST_RUN:     if (!en_i) state_d = ST_DISCH;
                    else if (uvp_i) state_d = ST_UVLATCH;
        ST_OVLATCH: if (!en_i) state_d = ST_IDLE;
        ST_UVLATCH: if (!en_i) state_d = ST_IDLE;
        ST_DISCH:   if (dis_low_i) state_d = ST_IDLE;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // counter restarts on every state change, so a restart always clears the ramp
  assign cnt_clr = (state_d != state_q);
  assign cnt_inc = tick_i &&
                   (state_q == ST_DELAY || state_q == ST_RAMP || state_q == ST_PGWAIT);

  seq_step_cnt #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt_q)
  );

  seq_ref_map #(.CODE_W(CODE_W), .CNT_W(CNT_W), .ARM_PCT(ARM_PCT)) u_map (
    .state_i   (state_q),
    .cnt_i     (cnt_q),
    .code_o    (ref_code_o),
    .uv_armed_o(uv_armed)
  );

  always_comb begin
    unique case (state_q)
      ST_RAMP, ST_PGWAIT, ST_RUN: gate_o = GATE_SWITCH;
      ST_OVLATCH, ST_DISCH:       gate_o = GATE_LOW_ON;
      default:                    gate_o = GATE_OFF;
    endcase
  end

  assign pgood_o = (state_q == ST_RUN) && !uvp_i && !ovp_i;

  // R9
  supply_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok |=> (gate_o == GATE_OFF && !pgood_o && ref_code_o == '0));

  // R4
  ovp_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovp_i && supply_ok) |=> (gate_o == GATE_LOW_ON && !pgood_o));

  // R2
  ramp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RAMP && tick_i && supply_ok && en_i && !ovp_i && !uvp_i &&
     ref_code_o != '1) |=> (ref_code_o == $past(ref_code_o) + 1'b1));

  // R5
  uv_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RAMP && !uv_armed && supply_ok && en_i && !ovp_i)
      |=> (ref_code_o >= $past(ref_code_o) && gate_o == GATE_SWITCH));

  // R7
  uv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UVLATCH && supply_ok && en_i && !ovp_i) |=> (gate_o == GATE_OFF && !pgood_o));

  // R3
  pgood_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o |-> (ref_code_o == '1 && gate_o == GATE_SWITCH && !uvp_i));
endmodule

// File: tb/softstart_prot_seq_bench.sv
module softstart_prot_seq_bench;
  localparam int RAMP = 1024;
  localparam int DLY  = 16;
  localparam int PGT  = 3;
  localparam int ARM  = (RAMP * 80) / 100;
  localparam int FULL = RAMP - 1;
  // model states
  localparam int S_IDLE = 0, S_DLY = 1, S_RAMP = 2, S_PGW = 3, S_RUN = 4,
                 S_OV = 5, S_UV = 6, S_DIS = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vcc = 1'b0, vccp = 1'b0, en = 1'b0, tick = 1'b0;
  logic ovp = 1'b0, uvp = 1'b0, dlow = 1'b0;
  logic [9:0] code;
  logic pgood;
  logic [1:0] gate;

  int n_run = 0, n_fail = 0;
  int m_st = S_IDLE, m_cnt = 0;

  always #2.5 clk = ~clk;

  softstart_prot_seq u_softstart_prot_seq (
    .clk_i(clk), .rst_ni(rst_n), .vcc_ok_i(vcc), .vccp_ok_i(vccp), .en_i(en),
    .tick_i(tick), .ovp_i(ovp), .uvp_i(uvp), .dis_low_i(dlow),
    .ref_code_o(code), .pgood_o(pgood), .gate_o(gate)
  );

  always @(posedge clk) begin
    #1 tick = rst_n ? ~tick : 1'b0;
  end

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    int nxt;
    if (!rst_n) begin
      m_st = S_IDLE; m_cnt = 0;
    end else begin
      nxt = m_st;
      if (!(vcc && vccp)) nxt = S_IDLE;
      else if (ovp) nxt = S_OV;
      else if (m_st == S_IDLE) begin if (en) nxt = S_DLY; end
      else if (m_st == S_OV || m_st == S_UV) begin if (!en) nxt = S_IDLE; end
      else if (m_st == S_DIS) begin if (dlow) nxt = S_IDLE; end
      else if (!en) nxt = S_DIS;
      else if (m_st == S_RUN) begin if (uvp) nxt = S_UV; end
      else if (uvp && ((m_st == S_RAMP && m_cnt >= ARM) || m_st == S_PGW)) nxt = S_DLY;
      else if (tick) begin
        if (m_st == S_DLY && m_cnt == DLY - 1) nxt = S_RAMP;
        else if (m_st == S_RAMP && m_cnt == RAMP - 1) nxt = S_PGW;
        else if (m_st == S_PGW && m_cnt == PGT - 1) nxt = S_RUN;
      end
      if (nxt != m_st) m_cnt = 0;
      else if (tick && (m_st == S_DLY || m_st == S_RAMP || m_st == S_PGW)) m_cnt++;
      m_st = nxt;
    end
  end

  function automatic int exp_code();
    if (m_st == S_RAMP) return m_cnt;
    if (m_st == S_PGW || m_st == S_RUN) return FULL;
    return 0;
  endfunction
  function automatic int exp_gate();
    if (m_st == S_RAMP || m_st == S_PGW || m_st == S_RUN) return 1;
    if (m_st == S_OV || m_st == S_DIS) return 2;
    return 0;
  endfunction
  function automatic int exp_pg();
    return (m_st == S_RUN && !uvp && !ovp) ? 1 : 0;
  endfunction
  function automatic string st_tag();
    case (m_st)
      S_IDLE: return "R1"; S_DLY: return "R2"; S_RAMP: return "R2"; S_PGW: return "R3";
      S_RUN: return "R3"; S_OV: return "R4"; S_UV: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(st_tag(), "code", int'(code), exp_code());
      check(st_tag(), "gate", int'(gate), exp_gate());
      check(st_tag(), "pgood", int'(pgood), exp_pg());
    end
  end

  task automatic drive_edge();
    @(posedge clk); #1;
  endtask
  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask
  task automatic wait_st(int s);
    while (m_st != s) @(negedge clk);
  endtask
  task automatic wait_ramp(int c);
    while (!(m_st == S_RAMP && m_cnt >= c)) @(negedge clk);
  endtask

  task automatic finish_tb();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_tb();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset code", int'(code), 0);
    check("R1", "reset gate", int'(gate), 0);
    check("R1", "reset pgood", int'(pgood), 0);
    drive_edge(); rst_n = 1'b1; en = 1'b1; vcc = 1'b1;
    repeat (20) @(negedge clk);
    check("R1", "no start without driver supply", int'(gate), 0);

    drive_edge(); vccp = 1'b1;
    repeat (DLY) @(negedge clk);
    check("R2", "gates off in delay", int'(gate), 0);
    wait_st(S_RAMP);
    check("R10", "switching encoding", int'(gate), 1);
    wait_ramp(100);
    drive_edge(); uvp = 1'b1;
    drive_edge(); uvp = 1'b0;
    @(negedge clk);
    check("R5", "early uvp keeps ramp", int'(gate), 1);
    check("R5", "early uvp keeps code", (code >= 100) ? 1 : 0, 1);
    wait_st(S_PGW);
    check("R2", "full scale at ramp end", int'(code), FULL);
    check("R3", "pgood low in wait", int'(pgood), 0);
    wait_st(S_RUN);
    check("R3", "pgood released", int'(pgood), 1);

    drive_edge(); uvp = 1'b1;
    @(negedge clk);
    check("R3", "pgood drops with uvp", int'(pgood), 0);
    drive_edge(); uvp = 1'b0;
    repeat (5) @(negedge clk);
    check("R7", "uv latch gates off", int'(gate), 0);
    check("R7", "uv latch pgood", int'(pgood), 0);
    drive_edge(); en = 1'b0;
    drive_edge(); en = 1'b1;

    wait_ramp(900);
    drive_edge(); uvp = 1'b1;
    drive_edge(); uvp = 1'b0;
    @(negedge clk);
    check("R6", "late uvp restart code", int'(code), 0);
    check("R6", "late uvp restart gate", int'(gate), 0);
    wait_st(S_RUN);

    drive_edge(); en = 1'b0;
    repeat (6) @(negedge clk);
    check("R8", "discharge bottom on", int'(gate), 2);
    check("R8", "discharge pgood", int'(pgood), 0);
    drive_edge(); dlow = 1'b1;
    settle();
    check("R8", "discharge ends idle", int'(gate), 0);
    drive_edge(); dlow = 1'b0; en = 1'b1;

    wait_ramp(300);
    drive_edge(); ovp = 1'b1;
    drive_edge(); ovp = 1'b0;
    repeat (8) @(negedge clk);
    check("R4", "ov latch bottom on", int'(gate), 2);
    check("R4", "ov latch code", int'(code), 0);
    drive_edge(); en = 1'b0;
    settle();
    check("R4", "ov cleared by enable", int'(gate), 0);
    drive_edge(); en = 1'b1;

    wait_st(S_RUN);
    drive_edge(); vcc = 1'b0;
    settle();
    check("R9", "supply loss idle gate", int'(gate), 0);
    check("R9", "supply loss pgood", int'(pgood), 0);
    drive_edge(); vcc = 1'b1;
    repeat (10) @(negedge clk);
    finish_tb();
  end
endmodule